// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the private cache controller of one core in a small shared-bus multiprocessor. It holds a few direct-mapped, one-word lines. Each line carries a tag, a data word and one of three coherence states: Invalid (2'b00), Shared (2'b01) or Modified (2'b10). Loads and stores from the core are served locally when the line state allows it. Otherwise the controller raises a bus request and names the transaction it needs. Dirty data stays in the cache until a conflicting line evicts it or another core claims it.

The controller also watches every transaction that the other cores place on the shared bus. A foreign read of a line held dirty makes the controller supply the word at once and fall back to Shared. A foreign read-exclusive or upgrade drops the local copy, so a single writer or any number of readers exist for each line. The arbiter and the memory sit outside the block. A granted transaction completes in the cycle of its grant. The core holds its request until `core_ready` rises, and after each bus transaction the core's access retries against the updated line.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address raises `bus_req`, and no snoop hits.
- R2: A load whose tag matches a Shared or Modified line gives `core_ready`=1 and the line's word on `core_rdata` in the same cycle, with `bus_req`=0.
- R3: A load that misses drives `bus_cmd`=1 (read) at the core address. When granted, it fills the line as Shared from `bus_rdata`, and the load completes in the next cycle. The core stays stalled while the grant is withheld.
- R4: A store that misses drives `bus_cmd`=2 (read-exclusive). When granted, it fills the line as Modified, and the store is written in the next cycle without more bus traffic.
- R5: A store to a Shared line drives `bus_cmd`=3 (upgrade). The grant moves the line to Modified and ignores `bus_rdata`.
- R6: A store to a Modified line completes with `core_ready`=1 in the same cycle and without a bus request. Later loads return the new word.
- R7: A snooped read (`snp_cmd`=1) of a Modified line sets `snp_flush` with the line's word in the same cycle and leaves the line Shared, so a later store needs an upgrade.
- R8: A snooped read-exclusive (`snp_cmd`=2) of a Modified line flushes the word and invalidates the line. A snooped read-exclusive or upgrade (`snp_cmd`=3) of a Shared line invalidates it without a flush.
- R9: A miss whose index holds a Modified line of another tag first drives `bus_cmd`=4 (writeback) with the victim's address {tag, index} and word. The fetch follows on the next grant.
- R10: A snooped read of a Shared line neither flushes nor changes the line.
- R11: A snoop whose tag differs from the indexed line, or that finds the line Invalid, has no effect.
- R12: No core access completes in a cycle with `snp_valid`=1. The access completes in the first cycle without a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access pending, held until ready |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | AW | Word address of the access |
| core_wdata | input | DW | Store data |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | DW | Load data, valid with core_ready |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_addr | output | AW | Address of the transaction |
| bus_wdata | output | DW | Writeback data |
| bus_rdata | input | DW | Fill data for a granted read or read-exclusive |
| snp_valid | input | 1 | Another core's transaction is on the bus |
| snp_cmd | input | 3 | Command of the snooped transaction |
| snp_addr | input | AW | Address of the snooped transaction |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DW | Supplied word |

## Verification
A wrong line state is not held inside the block for long. A line left Modified after a snooped read shows up at once: the next store to it completes with no upgrade on the bus. A missed invalidation shows up as a load hit in the same cycle, where a read request was expected. A wrong tag or fill word reaches the ports on the next access to that index, either through `core_rdata` or through the address and data of a writeback. The reference model therefore compares every output on every cycle, so that each state error is caught within the one or two cycles in which it first becomes visible.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_MOD = 2'b10
  } lstate_e;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_READ  = 3'd1,
    BC_READX = 3'd2,
    BC_UPGR  = 3'd3,
    BC_WBACK = 3'd4
  } bcmd_e;
endpackage

// File: rtl/scc_line_store.sv
module scc_line_store
  import scc_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IW    = 2,
  parameter int TW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx,
  output lstate_e       a_state,
  output logic [TW-1:0] a_tag,
  output logic [DW-1:0] a_data,
  input  logic [IW-1:0] b_idx,
  output lstate_e       b_state,
  output logic [TW-1:0] b_tag,
  output logic [DW-1:0] b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  lstate_e       wr_state,
  input  logic          wr_tag_en,
  input  logic [TW-1:0] wr_tag,
  input  logic          wr_data_en,
  input  logic [DW-1:0] wr_data
);
  lstate_e       st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_state;
      if (wr_tag_en)  tag_q[wr_idx] <= wr_tag;
      if (wr_data_en) dat_q[wr_idx] <= wr_data;
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];
endmodule

// File: rtl/scc_snoop_unit.sv
module scc_snoop_unit
  import scc_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [TW-1:0] snp_tag,
  input  lstate_e       l_state,
  input  logic [TW-1:0] l_tag,
  output logic          hit,
  output logic          flush,
  output logic          upd_en,
  output lstate_e       next_state
);
  logic is_rd, is_rdx, is_upg;

  always_comb begin
    is_rd  = (snp_cmd == BC_READ);
    is_rdx = (snp_cmd == BC_READX);
    is_upg = (snp_cmd == BC_UPGR);
    hit    = snp_valid && (l_state != LS_INV) && (l_tag == snp_tag);
    flush  = hit && (l_state == LS_MOD) && (is_rd || is_rdx);
    upd_en = hit && ((is_rd && l_state == LS_MOD) || is_rdx || is_upg);
    next_state = is_rd ? LS_SHR : LS_INV;
  end
endmodule

// File: rtl/scc_request_unit.sv
module scc_request_unit
  import scc_pkg::*;
#(
  parameter int IW = 2,
  parameter int TW = 6,
  parameter int DW = 32
) (
  input  logic             core_we,
  input  logic [IW-1:0]    core_idx,
  input  logic [TW-1:0]    core_tag,
  input  lstate_e          l_state,
  input  logic [TW-1:0]    l_tag,
  input  logic [DW-1:0]    l_data,
  output logic             local_ok,
  output bcmd_e            cmd,
  output logic [TW+IW-1:0] cmd_addr,
  output logic [DW-1:0]    cmd_wdata
);
  logic hit;

  always_comb begin
    hit       = (l_state != LS_INV) && (l_tag == core_tag);
    local_ok  = hit && (!core_we || l_state == LS_MOD);
    cmd       = BC_NONE;
    cmd_addr  = {core_tag, core_idx};
    cmd_wdata = '0;
    if (!local_ok) begin
      if (!hit && l_state == LS_MOD) begin
        cmd       = BC_WBACK;
        cmd_addr  = {l_tag, core_idx};
        cmd_wdata = l_data;
      end else if (!hit) begin
        cmd = core_we ? BC_READX : BC_READ;
      end else begin
        cmd = BC_UPGR;
      end
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import scc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ready,
  output logic [DW-1:0] core_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a);
    return a[IW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  lstate_e       c_state, s_state, snp_next, wr_state;
  logic [TW-1:0] c_tag, s_tag, wr_tag;
  logic [DW-1:0] c_data, s_data, wr_data;
  logic [IW-1:0] wr_idx;
  logic          wr_en, wr_tag_en, wr_data_en;
  logic          local_ok, snp_hit, snp_upd, own_grant;
  bcmd_e         req_cmd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  scc_line_store #(.LINES(LINES), .IW(IW), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(idx_of(core_addr)), .a_state(c_state), .a_tag(c_tag), .a_data(c_data),
    .b_idx(idx_of(snp_addr)),  .b_state(s_state), .b_tag(s_tag), .b_data(s_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
    .wr_tag_en(wr_tag_en), .wr_tag(wr_tag),
    .wr_data_en(wr_data_en), .wr_data(wr_data)
  );

  scc_snoop_unit #(.TW(TW)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(tag_of(snp_addr)),
    .l_state(s_state), .l_tag(s_tag),
    .hit(snp_hit), .flush(snp_flush), .upd_en(snp_upd), .next_state(snp_next)
  );

  scc_request_unit #(.IW(IW), .TW(TW), .DW(DW)) u_req (
    .core_we(core_we), .core_idx(idx_of(core_addr)), .core_tag(tag_of(core_addr)),
    .l_state(c_state), .l_tag(c_tag), .l_data(c_data),
    .local_ok(local_ok), .cmd(req_cmd), .cmd_addr(req_addr), .cmd_wdata(req_wdata)
  );

  assign core_ready = core_req && local_ok && !snp_valid;
  assign core_rdata = c_data;
  assign bus_req    = core_req && !local_ok;
  assign bus_cmd    = bus_req ? req_cmd : BC_NONE;
  assign bus_addr   = bus_req ? req_addr : '0;
  assign bus_wdata  = bus_req ? req_wdata : '0;
  assign own_grant  = bus_req && bus_gnt;
  assign snp_data   = snp_flush ? s_data : '0;

  // Update order: a snooped transaction first, then this core's granted
  // transaction, then a local store hit.
  always_comb begin
    wr_en      = 1'b0;
    wr_idx     = idx_of(core_addr);
    wr_state   = c_state;
    wr_tag_en  = 1'b0;
    wr_tag     = tag_of(core_addr);
    wr_data_en = 1'b0;
    wr_data    = bus_rdata;
    if (snp_upd) begin
      wr_en    = 1'b1;
      wr_idx   = idx_of(snp_addr);
      wr_state = snp_next;
    end else if (own_grant) begin
      wr_en = 1'b1;
      case (req_cmd)
        BC_WBACK: wr_state = LS_INV;
        BC_READ: begin
          wr_state = LS_SHR; wr_tag_en = 1'b1; wr_data_en = 1'b1;
        end
        BC_READX: begin
          wr_state = LS_MOD; wr_tag_en = 1'b1; wr_data_en = 1'b1;
        end
        BC_UPGR: wr_state = LS_MOD;
        default: wr_en = 1'b0;
      endcase
    end else if (core_ready && core_we) begin
      wr_en      = 1'b1;
      wr_state   = LS_MOD;
      wr_data_en = 1'b1;
      wr_data    = core_wdata;
    end
  end
endmodule

// File: rtl/snoop_cache_chk.sv
module snoop_cache_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_req,
  input logic          core_we,
  input logic [AW-1:0] core_addr,
  input logic          core_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [2:0]    bus_cmd,
  input logic          snp_valid,
  input logic [2:0]    snp_cmd,
  input logic [AW-1:0] snp_addr,
  input logic          snp_flush,
  input logic          snp_hit
);
  p_local_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> !bus_req);

  // R3: after a granted fetch or upgrade, the retried access completes at once
  p_fill_then_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd != 3'd4 && !snp_valid) |=>
      (snp_valid || !core_req || !$stable(core_addr) || !$stable(core_we) || core_ready));

  // R9: a writeback is followed by the fetch request, not by another writeback
  p_wb_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 3'd4 && !snp_valid) |=>
      (snp_valid || !core_req || !$stable(core_addr) || !$stable(core_we)
       || (bus_req && bus_cmd != 3'd4)));

  p_flush_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2)));

  p_rdx_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd == 3'd2) |=> !(snp_hit && $stable(snp_addr)));
endmodule

bind snoop_cache_ctrl snoop_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
  .core_addr(core_addr), .core_ready(core_ready), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_flush(snp_flush),
  .snp_hit(snp_hit)
);

// File: tb/snoop_cache_ctrl_bench.sv
module snoop_cache_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_ready;
  logic [DW-1:0] core_rdata;
  logic          bus_req, bus_gnt = 1'b0;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid = 1'b0;
  logic [2:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush;
  logic [DW-1:0] snp_data;

  always #4 clk = ~clk;

  snoop_cache_ctrl #(.AW(AW), .DW(DW), .LINES(NL)) u_snoop_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
    .core_rdata(core_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  // memory model and reference cache state (0 inv, 1 shared, 2 modified)
  logic [DW-1:0] mem [256];
  int            mst [NL];
  int            mtg [NL];
  logic [DW-1:0] mdat [NL];

  assign bus_rdata = (bus_cmd == 3'd3) ? 32'hDEAD_BEEF : mem[bus_addr];

  int    n_run = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit    last_ready;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    int ci, ct, si, st_, ecmd, eaddr;
    bit hit, eok, erdy, ebrq, eflush;
    logic [DW-1:0] ewd;
    #1;
    ci = int'(core_addr) % NL;  ct = int'(core_addr) / NL;
    si = int'(snp_addr) % NL;   st_ = int'(snp_addr) / NL;
    hit  = (mst[ci] != 0) && (mtg[ci] == ct);
    eok  = hit && (!core_we || mst[ci] == 2);
    erdy = core_req && eok && !snp_valid;
    ebrq = core_req && !eok;
    ecmd = 0; eaddr = 0; ewd = '0;
    if (ebrq) begin
      if (!hit && mst[ci] == 2) begin
        ecmd = 4; eaddr = mtg[ci] * NL + ci; ewd = mdat[ci];
      end else if (!hit) begin
        ecmd = core_we ? 2 : 1; eaddr = int'(core_addr);
      end else begin
        ecmd = 3; eaddr = int'(core_addr);
      end
    end
    eflush = snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2)
             && mst[si] == 2 && mtg[si] == st_;
    chk("core_ready", 32'(core_ready), 32'(erdy));
    chk("bus_req", 32'(bus_req), 32'(ebrq));
    chk("bus_cmd", 32'(bus_cmd), 32'(ecmd));
    if (ebrq) chk("bus_addr", 32'(bus_addr), 32'(eaddr));
    if (ecmd == 4) chk("bus_wdata", bus_wdata, ewd);
    if (erdy && !core_we) chk("core_rdata", core_rdata, mdat[ci]);
    chk("snp_flush", 32'(snp_flush), 32'(eflush));
    if (eflush) chk("snp_data", snp_data, mdat[si]);
    @(posedge clk);
    if (eflush) mem[snp_addr] = mdat[si];
    if (snp_valid && mst[si] != 0 && mtg[si] == st_) begin
      if (snp_cmd == 3'd1 && mst[si] == 2) mst[si] = 1;
      else if (snp_cmd == 3'd2 || snp_cmd == 3'd3) mst[si] = 0;
    end else if (ebrq && bus_gnt) begin
      case (ecmd)
        4: begin mem[eaddr] = ewd; mst[ci] = 0; end
        1: begin mst[ci] = 1; mtg[ci] = ct; mdat[ci] = mem[eaddr]; end
        2: begin mst[ci] = 2; mtg[ci] = ct; mdat[ci] = mem[eaddr]; end
        3: mst[ci] = 2;
        default: ;
      endcase
    end else if (erdy && core_we) begin
      mdat[ci] = core_wdata;
    end
    last_ready = erdy;
    @(negedge clk);
  endtask

  task automatic op(input string rq, input logic [AW-1:0] a, input bit we,
                    input logic [DW-1:0] d, input int gdelay);
    cur_req = rq;
    core_req = 1'b1; core_addr = a; core_we = we; core_wdata = d;
    for (int w = 0; w < 40; w++) begin
      bus_gnt = (w >= gdelay);
      step();
      if (last_ready) break;
    end
    core_req = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input string rq, input logic [AW-1:0] a, input logic [2:0] c);
    cur_req = rq;
    snp_valid = 1'b1; snp_addr = a; snp_cmd = c;
    step();
    snp_valid = 1'b0; snp_cmd = '0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i * 3);
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtg[i] = 0; mdat[i] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1"; step();                       // idle after reset
    snoop("R1", 8'h10, 3'd1);                     // no snoop hit after reset
    op("R1", 8'h10, 1'b0, '0, 0);                 // first access misses
    op("R2", 8'h10, 1'b0, '0, 0);                 // load hit in Shared
    op("R3", 8'h14, 1'b0, '0, 3);                 // miss with delayed grant
    op("R4", 8'h21, 1'b1, 32'h1111_2222, 0);      // store miss -> read-exclusive
    op("R6", 8'h21, 1'b1, 32'h3333_4444, 0);      // store hit Modified
    op("R6", 8'h21, 1'b0, '0, 0);
    op("R5", 8'h12, 1'b0, '0, 0);
    op("R5", 8'h12, 1'b1, 32'h5555_6666, 0);      // upgrade, garbage fill ignored
    op("R5", 8'h12, 1'b0, '0, 0);
    snoop("R7", 8'h21, 3'd1);                     // dirty supply, drop to Shared
    op("R7", 8'h21, 1'b1, 32'h7777_8888, 0);      // needs upgrade again
    snoop("R8", 8'h12, 3'd2);                     // dirty supply, invalidate
    op("R8", 8'h12, 1'b0, '0, 0);                 // reads flushed word from memory
    snoop("R10", 8'h12, 3'd1);                    // Shared line, no flush
    op("R10", 8'h12, 1'b0, '0, 0);
    snoop("R8", 8'h14, 3'd3);                     // upgrade kills Shared copy
    op("R8", 8'h14, 1'b0, '0, 0);
    op("R9", 8'h31, 1'b0, '0, 0);                 // evicts dirty 0x21 first
    op("R9", 8'h21, 1'b0, '0, 0);
    snoop("R11", 8'h02, 3'd2);                    // other tag on index 2
    snoop("R11", 8'h13, 3'd2);                    // Invalid line on index 3
    op("R11", 8'h12, 1'b0, '0, 0);
    cur_req = "R12";                              // local hit blocked by snoop
    core_req = 1'b1; core_addr = 8'h12; core_we = 1'b0;
    snp_valid = 1'b1; snp_addr = 8'h31; snp_cmd = 3'd1;
    step();
    snp_valid = 1'b0; snp_cmd = '0;
    step();
    core_req = 1'b0;
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ra;
      ra = 8'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0)
        snoop("R11", ra, 3'($urandom_range(1, 3)));
      else
        op("R2", ra, 1'($urandom_range(0, 1)), $urandom, int'($urandom_range(0, 2)));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule